// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Sign, Overflow, Zero and Carry Flags

This combinational unit performs every data operation of a small 8-bit accumulator processor in a single pass. Each cycle the sequencer presents an operation code, a register operand on `a_i`, a memory or immediate operand on `b_i`, and the present carry and overflow flags. The unit returns the computed byte, a strobe saying whether that byte is stored, and the next value of each status flag with its own write strobe. Flags that an operation does not touch keep the values that came in.

Shifts, rotates, increment and decrement act on `a_i`. For memory forms, the sequencer places the memory byte on `a_i`. Loads and register transfers place their source byte on `b_i` and use the pass operation. Subtraction adds the inverted operand plus the carry, so a carry of 1 means no borrow occurred. A compare changes flags only. Decimal arithmetic, the interrupt and break flags, and register storage belong elsewhere.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) writes R = (a + b + c_i) mod 256 and sets C to 1 exactly when a + b + c_i > 255. It writes N, V, Z and C.
- R2: Code 1 (subtract) writes R = (a + (255 − b) + c_i) mod 256, and C is the carry out of that sum (1 = no borrow). It writes N, V, Z and C.
- R3: For add, V = bit 7 of ((a ^ R) & (b ^ R)). For subtract the same formula is used with b replaced by its inverse. V is written only by codes 0, 1 and 13.
- R4: Code 2 (compare) asserts no result write. It writes C = (a ≥ b unsigned), Z = (a == b), N = bit 7 of (a − b) mod 256, and leaves V unwritten.
- R5: Codes 3, 4 and 5 write a AND b, a OR b and a XOR b respectively. They write only N and Z.
- R6: Code 6 (shift left) writes (a << 1) mod 256 with C = a[7]. Code 7 (shift right) writes a >> 1 with C = a[0]. Both write N, Z and C.
- R7: Code 8 (rotate left) writes ((a << 1) | c_i) mod 256 with C = a[7]. Code 9 (rotate right) writes (a >> 1) | (c_i << 7) with C = a[0]. Both write N, Z and C.
- R8: Code 10 writes (a + 1) mod 256 and code 11 writes (a + 255) mod 256. Both write only N and Z.
- R9: Code 12 (pass) writes b unchanged and writes only N and Z.
- R10: Whenever N or Z is written, N equals bit 7 of the result byte and Z is 1 exactly when that byte is zero. For compare the result byte is the difference.
- R11: Code 13 writes V = 0, code 14 writes C = 1 and code 15 writes C = 0. Each writes no result and no other flag.
- R12: Codes 16 to 31 write no result and no flag.
- R13: When V is not written, v_o equals v_i. When C is not written, c_o equals c_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Register operand (also the target of shift, rotate, increment and decrement) |
| b_i | input | 8 | Memory or immediate operand |
| c_i | input | 1 | Present carry flag |
| v_i | input | 1 | Present overflow flag |
| res_o | output | 8 | Computed result byte |
| res_we_o | output | 1 | Result is to be stored |
| n_o | output | 1 | Next sign flag |
| n_we_o | output | 1 | Sign flag write strobe |
| v_o | output | 1 | Next overflow flag |
| v_we_o | output | 1 | Overflow flag write strobe |
| z_o | output | 1 | Next zero flag |
| z_we_o | output | 1 | Zero flag write strobe |
| c_o | output | 1 | Next carry flag |
| c_we_o | output | 1 | Carry flag write strobe |

## Verification
Every one of the 32 operation codes is applied with both carry and overflow inputs at 0 and 1, against a grid of operands: 0x00, 0x01, 0x7F, 0x80, 0x81, 0xFE, 0xFF and 0x55. On this grid, signed overflow is told apart from unsigned carry for add and subtract. Equality is told apart from ordering for compare, and the wrap of increment and decrement is exercised at the top and bottom of the byte range. Random operand pairs then cover mixed bit patterns that separate AND, OR and XOR, and that show whether the incoming carry enters a rotate at the correct end.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_CMP  = 5'd2,
        OP_AND  = 5'd3,
        OP_OR   = 5'd4,
        OP_XOR  = 5'd5,
        OP_SHL  = 5'd6,
        OP_SHR  = 5'd7,
        OP_ROTL = 5'd8,
        OP_ROTR = 5'd9,
        OP_INC  = 5'd10,
        OP_DEC  = 5'd11,
        OP_PASS = 5'd12,
        OP_VCLR = 5'd13,
        OP_CSET = 5'd14,
        OP_CCLR = 5'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ADD,
        SEL_LOGIC,
        SEL_SHIFT,
        SEL_PASS
    } res_sel_e;

    typedef struct packed {
        res_sel_e sel;
        logic     res_we;
        logic     n_we;
        logic     v_we;
        logic     z_we;
        logic     c_we;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(logic [OP_W-1:0] op);
        alu_ctrl_t ctl;
        ctl = '{sel: SEL_NONE, res_we: 1'b0, n_we: 1'b0, v_we: 1'b0, z_we: 1'b0, c_we: 1'b0};
        case (op)
            OP_ADD, OP_SUB: ctl = '{sel: SEL_ADD, res_we: 1'b1, n_we: 1'b1, v_we: 1'b1, z_we: 1'b1, c_we: 1'b1};
            OP_CMP:         ctl = '{sel: SEL_ADD, res_we: 1'b0, n_we: 1'b1, v_we: 1'b0, z_we: 1'b1, c_we: 1'b1};
            OP_AND, OP_OR, OP_XOR:
                            ctl = '{sel: SEL_LOGIC, res_we: 1'b1, n_we: 1'b1, v_we: 1'b0, z_we: 1'b1, c_we: 1'b0};
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR:
                            ctl = '{sel: SEL_SHIFT, res_we: 1'b1, n_we: 1'b1, v_we: 1'b0, z_we: 1'b1, c_we: 1'b1};
            OP_INC, OP_DEC: ctl = '{sel: SEL_ADD, res_we: 1'b1, n_we: 1'b1, v_we: 1'b0, z_we: 1'b1, c_we: 1'b0};
            OP_PASS:        ctl = '{sel: SEL_PASS, res_we: 1'b1, n_we: 1'b1, v_we: 1'b0, z_we: 1'b1, c_we: 1'b0};
            OP_VCLR:        ctl.v_we = 1'b1;
            OP_CSET, OP_CCLR: ctl.c_we = 1'b1;
            default:        ;
        endcase
        return ctl;
    endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int unsigned W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W:0] full;

    assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
    // signed overflow: both inputs disagree in sign with the sum
    assign ovf_o  = (a_i[W-1] ^ full[W-1]) & (b_i[W-1] ^ full[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int unsigned W = alu8_pkg::DATA_W
) (
    input  logic [alu8_pkg::OP_W-1:0] op_i,
    input  logic [W-1:0]              a_i,
    input  logic [W-1:0]              b_i,
    output logic [W-1:0]              res_o
);
    import alu8_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (op_i)
                OP_AND:  res_o[i] = a_i[i] & b_i[i];
                OP_OR:   res_o[i] = a_i[i] | b_i[i];
                default: res_o[i] = a_i[i] ^ b_i[i];
            endcase
        end
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter int unsigned W = alu8_pkg::DATA_W
) (
    input  logic [alu8_pkg::OP_W-1:0] op_i,
    input  logic [W-1:0]              a_i,
    input  logic                      cin_i,
    output logic [W-1:0]              res_o,
    output logic                      cout_o
);
    import alu8_pkg::*;

    logic fill_lo;
    logic fill_hi;

    // rotates feed the incoming carry into the vacated end
    assign fill_lo = (op_i == OP_ROTL) ? cin_i : 1'b0;
    assign fill_hi = (op_i == OP_ROTR) ? cin_i : 1'b0;

    always_comb begin
        if (op_i == OP_SHL || op_i == OP_ROTL) begin
            res_o  = {a_i[W-2:0], fill_lo};
            cout_o = a_i[W-1];
        end else begin
            res_o  = {fill_hi, a_i[W-1:1]};
            cout_o = a_i[0];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int unsigned W = alu8_pkg::DATA_W
) (
    input  logic [alu8_pkg::OP_W-1:0] op_i,
    input  logic [W-1:0]              a_i,
    input  logic [W-1:0]              b_i,
    input  logic                      c_i,
    input  logic                      v_i,
    output logic [W-1:0]              res_o,
    output logic                      res_we_o,
    output logic                      n_o,
    output logic                      n_we_o,
    output logic                      v_o,
    output logic                      v_we_o,
    output logic                      z_o,
    output logic                      z_we_o,
    output logic                      c_o,
    output logic                      c_we_o
);
    import alu8_pkg::*;

    alu_ctrl_t  ctl;
    logic [W-1:0] add_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] log_res;
    logic [W-1:0] sh_res;
    logic         sh_cout;

    assign ctl = decode_op(op_i);

    // operand steering: subtraction and compare reuse the adder with ~b
    always_comb begin
        add_b   = b_i;
        add_cin = c_i;
        case (op_i)
            OP_SUB:  add_b = ~b_i;
            OP_CMP:  begin add_b = ~b_i;   add_cin = 1'b1; end
            OP_INC:  begin add_b = '0;     add_cin = 1'b1; end
            OP_DEC:  begin add_b = '1;     add_cin = 1'b0; end
            default: ;
        endcase
    end

    alu8_adder #(.W(W)) u_adder (
        .a_i(a_i), .b_i(add_b), .cin_i(add_cin),
        .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    alu8_logic #(.W(W)) u_logic (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(log_res)
    );

    alu8_shifter #(.W(W)) u_shifter (
        .op_i(op_i), .a_i(a_i), .cin_i(c_i), .res_o(sh_res), .cout_o(sh_cout)
    );

    always_comb begin
        case (ctl.sel)
            SEL_ADD:   res_o = add_sum;
            SEL_LOGIC: res_o = log_res;
            SEL_SHIFT: res_o = sh_res;
            SEL_PASS:  res_o = b_i;
            default:   res_o = '0;
        endcase
    end

    always_comb begin
        case (op_i)
            OP_ADD, OP_SUB:   v_o = add_ovf;
            OP_VCLR:          v_o = 1'b0;
            default:          v_o = v_i;
        endcase
        case (op_i)
            OP_ADD, OP_SUB, OP_CMP:            c_o = add_cout;
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR:  c_o = sh_cout;
            OP_CSET:                           c_o = 1'b1;
            OP_CCLR:                           c_o = 1'b0;
            default:                           c_o = c_i;
        endcase
    end

    assign n_o      = res_o[W-1];
    assign z_o      = (res_o == '0);
    assign res_we_o = ctl.res_we;
    assign n_we_o   = ctl.n_we;
    assign v_we_o   = ctl.v_we;
    assign z_we_o   = ctl.z_we;
    assign c_we_o   = ctl.c_we;
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
    parameter int unsigned W = alu8_pkg::DATA_W
) (
    input logic [alu8_pkg::OP_W-1:0] op_i,
    input logic [W-1:0]              a_i,
    input logic [W-1:0]              b_i,
    input logic                      c_i,
    input logic                      v_i,
    input logic [W-1:0]              res_o,
    input logic                      res_we_o,
    input logic                      n_o,
    input logic                      n_we_o,
    input logic                      v_o,
    input logic                      v_we_o,
    input logic                      z_o,
    input logic                      z_we_o,
    input logic                      c_o,
    input logic                      c_we_o
);
    import alu8_pkg::*;

    always_comb begin
        if (!v_we_o) AST_V_HELD: assert (v_o == v_i);                                   // R13
        if (!c_we_o) AST_C_HELD: assert (c_o == c_i);                                   // R13
        if (op_i == OP_CMP) AST_CMP_NO_STORE: assert (!res_we_o && !v_we_o && c_o == (a_i >= b_i)); // R4
        if (v_we_o) AST_V_ONLY_ARITH: assert (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_VCLR); // R3
        if (op_i == OP_INC || op_i == OP_DEC) AST_STEP_NZ_ONLY: assert (!c_we_o && !v_we_o && n_we_o && z_we_o); // R8
        if (op_i == OP_PASS) AST_PASS_COPY: assert (res_we_o && res_o == b_i);          // R9
        if (op_i >= OP_VCLR) AST_FLAGOP_NO_STORE: assert (!res_we_o && !n_we_o && !z_we_o); // R11
        if (op_i > OP_CCLR) AST_SPARE_IDLE: assert (!v_we_o && !c_we_o);                // R12
        if (n_we_o && z_we_o) AST_NZ_MATCH: assert (n_o == res_o[W-1] && z_o == (res_o == '0)); // R10
    end
endmodule

bind alu8_core alu8_checker #(.W(W)) u_alu8_checker (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .v_i(v_i),
    .res_o(res_o), .res_we_o(res_we_o),
    .n_o(n_o), .n_we_o(n_we_o), .v_o(v_o), .v_we_o(v_we_o),
    .z_o(z_o), .z_we_o(z_we_o), .c_o(c_o), .c_we_o(c_we_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0] op = 5'd31;
    logic [7:0] a  = 8'h00;
    logic [7:0] b  = 8'h00;
    logic       ci = 1'b0;
    logic       vi = 1'b0;
    logic [7:0] res;
    logic       res_we, n, n_we, v, v_we, z, z_we, c, c_we;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    alu8_core i_alu8_core (
        .op_i(op), .a_i(a), .b_i(b), .c_i(ci), .v_i(vi),
        .res_o(res), .res_we_o(res_we),
        .n_o(n), .n_we_o(n_we), .v_o(v), .v_we_o(v_we),
        .z_o(z), .z_we_o(z_we), .c_o(c), .c_we_o(c_we)
    );

    // expected behaviour, computed from the requirement text
    int e_res, e_n, e_v, e_z, e_c;
    bit e_we, e_nw, e_vw, e_zw, e_cw;
    string tag;

    task automatic model(input int o, input int x, input int y, input int cin, input int vin);
        int s;
        e_res = 0; e_we = 0; e_nw = 0; e_vw = 0; e_zw = 0; e_cw = 0;
        e_v = vin; e_c = cin; tag = "R12";
        case (o)
            0: begin s = x + y + cin; e_res = s % 256; e_c = (s > 255);
                     e_v = (((x ^ e_res) & (y ^ e_res) & 128) != 0);
                     e_we = 1; e_nw = 1; e_vw = 1; e_zw = 1; e_cw = 1; tag = "R1"; end
            1: begin s = x + (255 - y) + cin; e_res = s % 256; e_c = (s > 255);
                     e_v = (((x ^ e_res) & ((255 - y) ^ e_res) & 128) != 0);
                     e_we = 1; e_nw = 1; e_vw = 1; e_zw = 1; e_cw = 1; tag = "R2"; end
            2: begin e_res = (x - y + 256) % 256; e_c = (x >= y);
                     e_nw = 1; e_zw = 1; e_cw = 1; tag = "R4"; end
            3: begin e_res = x & y; e_we = 1; e_nw = 1; e_zw = 1; tag = "R5"; end
            4: begin e_res = x | y; e_we = 1; e_nw = 1; e_zw = 1; tag = "R5"; end
            5: begin e_res = x ^ y; e_we = 1; e_nw = 1; e_zw = 1; tag = "R5"; end
            6: begin e_res = (x * 2) % 256; e_c = x / 128; e_we = 1; e_nw = 1; e_zw = 1; e_cw = 1; tag = "R6"; end
            7: begin e_res = x / 2; e_c = x % 2; e_we = 1; e_nw = 1; e_zw = 1; e_cw = 1; tag = "R6"; end
            8: begin e_res = (x * 2 + cin) % 256; e_c = x / 128; e_we = 1; e_nw = 1; e_zw = 1; e_cw = 1; tag = "R7"; end
            9: begin e_res = x / 2 + cin * 128; e_c = x % 2; e_we = 1; e_nw = 1; e_zw = 1; e_cw = 1; tag = "R7"; end
            10: begin e_res = (x + 1) % 256; e_we = 1; e_nw = 1; e_zw = 1; tag = "R8"; end
            11: begin e_res = (x + 255) % 256; e_we = 1; e_nw = 1; e_zw = 1; tag = "R8"; end
            12: begin e_res = y; e_we = 1; e_nw = 1; e_zw = 1; tag = "R9"; end
            13: begin e_v = 0; e_vw = 1; tag = "R11"; end
            14: begin e_c = 1; e_cw = 1; tag = "R11"; end
            15: begin e_c = 0; e_cw = 1; tag = "R11"; end
            default: ;
        endcase
        e_n = e_res / 128;
        e_z = (e_res == 0);
    endtask

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s op=%0d a=%02h b=%02h c=%0d v=%0d actual=%0h expected=%0h",
                     rq, what, op, a, b, ci, vi, act, exp);
        end
    endtask

    task automatic apply(input int o, input int x, input int y, input int cin, input int vin);
        @(negedge clk);
        op = o[4:0]; a = x[7:0]; b = y[7:0]; ci = cin[0]; vi = vin[0];
        model(o, x, y, cin, vin);
        @(posedge clk);
        #1;
        chk(tag, "res_we", int'(res_we), int'(e_we));
        if (e_we) chk(tag, "res", int'(res), e_res);
        chk(tag, "n_we", int'(n_we), int'(e_nw));
        chk(tag, "z_we", int'(z_we), int'(e_zw));
        chk((o == 0 || o == 1 || o == 13) ? "R3" : tag, "v_we", int'(v_we), int'(e_vw));
        chk(tag, "c_we", int'(c_we), int'(e_cw));
        if (e_nw) chk("R10", "n", int'(n), e_n);
        if (e_zw) chk("R10", "z", int'(z), e_z);
        chk(e_vw ? ((o == 13) ? "R11" : "R3") : "R13", "v", int'(v), e_v);
        chk(e_cw ? tag : "R13", "c", int'(c), e_c);
    endtask

    int grid [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h55};

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: spare code 31 with zero operands, nothing written (R12)
        #1;
        chk("R12", "reset res_we", int'(res_we), 0);
        chk("R12", "reset c_we", int'(c_we), 0);
        // directed corner cases
        apply(0, 8'h7F, 8'h01, 0, 0);   // R1 signed overflow, no carry
        apply(0, 8'hFF, 8'h01, 0, 1);   // R1 carry and zero, no overflow
        apply(1, 8'h00, 8'h01, 1, 0);   // R2 borrow wraps to FF
        apply(1, 8'h80, 8'h01, 1, 0);   // R2 signed overflow on subtract
        apply(2, 8'h42, 8'h42, 0, 1);   // R4 equal compare
        apply(2, 8'h10, 8'h20, 1, 0);   // R4 less-than compare
        apply(10, 8'hFF, 8'h00, 1, 1);  // R8 increment wraps to 00
        apply(11, 8'h00, 8'h00, 0, 0);  // R8 decrement wraps to FF
        apply(9, 8'h01, 8'h00, 1, 0);   // R7 rotate right carry in at bit 7
        apply(8, 8'h80, 8'h00, 0, 0);   // R7 rotate left gives zero, carry out
        // full code sweep over the operand grid
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int f = 0; f < 4; f++)
                        apply(o, grid[i], grid[j], f % 2, f / 2);
        // random operands
        for (int k = 0; k < 3000; k++)
            apply(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 1)));
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule